// File: doc/BRIEF.md
# I2C Register-Access Slave with Persistent Command Pointer

This block is the serial front end of a register-mapped peripheral. It watches a two-wire I2C-compatible bus through a system clock that runs much faster than the bus. It rejects short spikes on both lines and recognises START, repeated START and STOP. It accepts transfers addressed to a 7-bit slave address. That address is fixed in its upper three bits (binary 100). The lower four bits come from two pin-state codes that a separate sensing circuit supplies.

The first byte of a write transfer sets an internal command pointer. Every later byte is either written to the register the pointer names or read from it. The pointer steps forward by one after each byte and stops at its top value. It survives STOP and repeated START, so a master can set the pointer in one transfer and read from it in the next. The block drives SDA only as an open-drain pull-down enable. It presents a simple register port: an address, a one-cycle write strobe with data, and a one-cycle read strobe that samples the read data.

Top module: `i2c_cmd_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {1,0,0,addr_hi_i[1:0],addr_lo_i[1:0]}. To acknowledge, it holds SDA low through the ninth clock. On a mismatch it leaves SDA released and ignores all bus activity until the next START.
- R2: In a write transfer, bits 6:0 of the first byte after the address load the command pointer and bit 7 is discarded. The pointer keeps its value when a STOP follows at once.
- R3: Each later byte of a write transfer produces one reg_wr_o pulse. The pulse carries the byte on reg_wdata_o and the pointer on reg_addr_o. It occurs while SCL is high during that byte's acknowledge bit, with the slave pulling SDA low.
- R4: After every data byte, written or read, the pointer increments by one if its value is 0x00 to 0x7E. At 0x7F it stays at 0x7F.
- R5: In a read transfer, the slave pulses reg_rd_o once per byte and samples reg_rdata_i at the current pointer. It shifts that byte out MSB first. The first byte comes from the stored pointer.
- R6: A repeated START between the pointer-setting write and a read leaves the pointer unchanged, so the read begins at the pointer just written.
- R7: A master NACK after a read byte ends the burst. The slave drives SDA no more and issues no more read strobes until the next START.
- R8: A level change on SCL or SDA lasting fewer than FILT_CNT system-clock samples (12 by default, 60 ns at 200 MHz) is ignored.
- R9: sda_oe_o changes only while SCL is low, and each strobe lasts exactly one clock.
- R10: After reset, sda_oe_o, reg_wr_o and reg_rd_o are 0 and reg_addr_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | High enables the open-drain pull-down on SDA |
| addr_hi_i | input | 2 | State code of the upper address pin (address bits 3:2) |
| addr_lo_i | input | 2 | State code of the lower address pin (address bits 1:0) |
| reg_addr_o | output | PTR_W | Command pointer, register address for both strobes |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Byte written with reg_wr_o |
| reg_rd_o | output | 1 | One-cycle strobe at which reg_rdata_i is sampled |
| reg_rdata_i | input | 8 | Register contents at reg_addr_o |

## Verification
Some rules are checked on every cycle. Changes of the pull-down enable must fall in SCL-low time. Write strobes must land inside a driven acknowledge while SCL is high, with the register address held steady. Both strobes must be single-cycle pulses, and the read strobe must fire only while SCL is low.

Other behaviour can only be shown by the bench's scenarios. These cover the address decode for more than one pin setting and pointer loading with bit 7 discarded. They also cover saturation at 0x7F for both writes and reads, pointer retention across STOP and repeated START, silence after a master NACK or a foreign address, and rejection of spikes shorter than the filter window.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } st_e;
endpackage

// File: rtl/i2cs_filter.sv
module i2cs_filter #(
  parameter int CNT = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(CNT + 1);

  logic [1:0]    sync_q;
  logic          q_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      q_q    <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], d_i};
      if (sync_q[1] == q_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(CNT - 1)) begin
        q_q   <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o  = scl_q & scl_i & ~sda_q & sda_i;
  assign rise_o  = ~scl_q & scl_i;
  assign fall_o  = scl_q & ~scl_i;
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int PTR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sda_i,
  input  logic [6:0]        dev_addr_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              wr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              rd_o
);
  st_e               st_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, wdata_q;
  logic [PTR_W-1:0]  ptr_q, ptr_inc;
  logic              mack_q, wr_q, rd_q;

  // saturate at all-ones
  assign ptr_inc = (ptr_q == '1) ? ptr_q : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      mack_q  <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (start_i) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_CMD, ST_WR: begin
            if (rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (fall_i && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (st_q == ST_ADDR)
                st_q <= (sh_q[7:1] == dev_addr_i) ? ST_ADDR_ACK : ST_IDLE;
              else if (st_q == ST_CMD)
                st_q <= ST_CMD_ACK;
              else
                st_q <= ST_WR_ACK;
            end
          end
          ST_ADDR_ACK: begin
            if (fall_i) begin
              if (sh_q[0]) begin
                st_q <= ST_RD;
                tx_q <= rdata_i;
                rd_q <= 1'b1;
              end else begin
                st_q <= ST_CMD;
              end
            end
          end
          ST_CMD_ACK: begin
            if (rise_i) ptr_q <= sh_q[PTR_W-1:0];
            if (fall_i) st_q <= ST_WR;
          end
          ST_WR_ACK: begin
            if (rise_i) begin
              wr_q    <= 1'b1;
              wdata_q <= sh_q;
            end
            if (fall_i) begin
              st_q  <= ST_WR;
              ptr_q <= ptr_inc;
            end
          end
          ST_RD: begin
            if (rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (fall_i) begin
              if (cnt_q == 4'd8) begin
                st_q  <= ST_RD_ACK;
                cnt_q <= '0;
                ptr_q <= ptr_inc;
              end else begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (rise_i) begin
              mack_q <= ~sda_i;
            end else if (fall_i) begin
              if (mack_q) begin
                st_q <= ST_RD;
                tx_q <= rdata_i;
                rd_q <= 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_ADDR_ACK, ST_CMD_ACK, ST_WR_ACK: sda_oe_o = 1'b1;
      ST_RD:                              sda_oe_o = ~tx_q[BYTE_W-1];
      default:                            sda_oe_o = 1'b0;
    endcase
  end

  assign ptr_o   = ptr_q;
  assign wr_o    = wr_q;
  assign wdata_o = wdata_q;
  assign rd_o    = rd_q;
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
  import i2cs_pkg::*;
#(
  parameter int         FILT_CNT    = 12,
  parameter int         PTR_W       = 7,
  parameter logic [2:0] ADDR_PREFIX = 3'b100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [1:0]        addr_hi_i,
  input  logic [1:0]        addr_lo_i,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic              reg_wr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_rd_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  logic start, stop, rise, fall;

  assign raw = {scl_i, sda_i};

  for (genvar i = 0; i < NLINES; i++) begin : g_filt
    i2cs_filter #(.CNT(FILT_CNT)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[i]),
      .q_o   (filt[i])
    );
  end

  i2cs_cond u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (filt[1]),
    .sda_i  (filt[0]),
    .start_o(start),
    .stop_o (stop),
    .rise_o (rise),
    .fall_o (fall)
  );

  i2cs_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .stop_i    (stop),
    .rise_i    (rise),
    .fall_i    (fall),
    .sda_i     (filt[0]),
    .dev_addr_i({ADDR_PREFIX, addr_hi_i, addr_lo_i}),
    .rdata_i   (reg_rdata_i),
    .sda_oe_o  (sda_oe_o),
    .ptr_o     (reg_addr_o),
    .wr_o      (reg_wr_o),
    .wdata_o   (reg_wdata_o),
    .rd_o      (reg_rd_o)
  );
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk #(
  parameter int PTR_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic [PTR_W-1:0] reg_addr_o,
  input logic             reg_wr_o,
  input logic             reg_rd_o
);
  // R9
  oe_edge_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  // R3
  wr_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (sda_oe_o && scl_i));

  // R3
  wr_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> $stable(reg_addr_o));

  // R9
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  // R5
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);

  // R5
  rd_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |-> !scl_i);
endmodule

bind i2c_cmd_slave i2cs_chk #(.PTR_W(PTR_W)) u_chk (.*);

// File: tb/tb_i2c_cmd_slave.sv
`timescale 1ns/1ps
module tb_i2c_cmd_slave;
  localparam int Q = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] addr_hi = 2'b01;
  logic [1:0] addr_lo = 2'b10;
  logic       sda_oe;
  logic [6:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  wire        sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem [0:127];
  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0, wr_scl_bad = 0, oe_hits = 0;
  bit oe_watch = 0, done = 0;

  always #2.5 clk = ~clk;

  i2c_cmd_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_hi_i(addr_hi), .addr_lo_i(addr_lo),
    .reg_addr_o(reg_addr), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata),
    .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr) begin
        mem[reg_addr] <= reg_wdata;
        wr_cnt++;
        if (!scl_m || !sda_oe) wr_scl_bad++;
      end
      if (reg_rd) rd_cnt++;
      if (oe_watch && sda_oe) oe_hits++;
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      if (glitch && i == 4) begin
        w(10); scl_m = 1'b1; w(8); scl_m = 1'b0; w(Q - 18);
      end else begin
        w(Q);
      end
      scl_m = 1'b1;
      if (glitch && i == 2) begin
        w(30); sda_m = 1'b0; w(8); sda_m = 1'b1; w(2*Q - 38);
      end else begin
        w(2*Q);
      end
      scl_m = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q);
    ack = !sda_bus;
    w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl_m = 1'b1; w(Q); b[i] = sda_bus; w(Q); scl_m = 1'b0;
    end
    w(Q); sda_m = nack; w(Q); scl_m = 1'b1; w(2*Q); scl_m = 1'b0; sda_m = 1'b1; w(Q);
  endtask

  task automatic t_reset;
    chk("R10 sda_oe", sda_oe, 0);
    chk("R10 reg_wr", reg_wr, 0);
    chk("R10 reg_rd", reg_rd, 0);
    chk("R10 reg_addr", reg_addr, 0);
  endtask

  task automatic t_write_burst;
    bit a; int w0 = wr_cnt;
    bus_start;
    send_byte(8'h8C, 0, a); chk("R1 address ack", a, 1);
    send_byte(8'h10, 0, a); chk("R2 command ack", a, 1);
    send_byte(8'hA5, 0, a); chk("R3 data ack", a, 1);
    send_byte(8'h3C, 0, a);
    bus_stop;
    chk("R3 first write", mem[8'h10], 8'hA5);
    chk("R3 second write", mem[8'h11], 8'h3C);
    chk("R3 strobe count", wr_cnt - w0, 2);
    chk("R3 strobe in ack with SCL high", wr_scl_bad, 0);
    chk("R4 pointer after two writes", reg_addr, 8'h12);
  endtask

  task automatic t_cmd_only;
    bit a; int w0 = wr_cnt;
    bus_start;
    send_byte(8'h8C, 0, a);
    send_byte(8'h85, 0, a);
    bus_stop;
    chk("R2 pointer kept after STOP, bit7 dropped", reg_addr, 8'h05);
    chk("R2 no write on pointer byte", wr_cnt - w0, 0);
  endtask

  task automatic t_saturate_write;
    bit a;
    bus_start;
    send_byte(8'h8C, 0, a);
    send_byte(8'h7E, 0, a);
    send_byte(8'h11, 0, a);
    send_byte(8'h22, 0, a);
    send_byte(8'h33, 0, a);
    bus_stop;
    chk("R4 write at 0x7E", mem[8'h7E], 8'h11);
    chk("R4 saturated overwrite at 0x7F", mem[8'h7F], 8'h33);
    chk("R4 pointer held at 0x7F", reg_addr, 8'h7F);
  endtask

  task automatic t_read_rstart;
    bit a; logic [7:0] d; int r0;
    mem[8'h20] = 8'h5A; mem[8'h21] = 8'hC3;
    bus_start;
    send_byte(8'h8C, 0, a);
    send_byte(8'h20, 0, a);
    bus_start;
    r0 = rd_cnt;
    send_byte(8'h8D, 0, a); chk("R1 read address ack", a, 1);
    recv_byte(0, d); chk("R6 first byte after repeated START", d, 8'h5A);
    recv_byte(1, d); chk("R5 second read byte", d, 8'hC3);
    chk("R4 pointer after two reads", reg_addr, 8'h22);
    chk("R5 read strobes", rd_cnt - r0, 2);
    oe_watch = 1;
    recv_byte(1, d);
    oe_watch = 0;
    bus_stop;
    chk("R7 bus released after NACK", d, 8'hFF);
    chk("R7 no drive after NACK", oe_hits, 0);
    chk("R7 no strobe after NACK", rd_cnt - r0, 2);
    chk("R7 pointer unchanged after NACK", reg_addr, 8'h22);
  endtask

  task automatic t_mismatch;
    bit a; int w0 = wr_cnt;
    bus_start;
    oe_watch = 1;
    send_byte(8'h90, 0, a); chk("R1 foreign address not acked", a, 0);
    send_byte(8'h33, 0, a); chk("R1 following byte not acked", a, 0);
    oe_watch = 0;
    bus_stop;
    chk("R1 no drive after mismatch", oe_hits, 0);
    chk("R1 pointer unchanged", reg_addr, 8'h22);
    chk("R1 no write after mismatch", wr_cnt - w0, 0);
  endtask

  task automatic t_read_saturate;
    bit a; logic [7:0] d;
    addr_hi = 2'b11; addr_lo = 2'b00;
    w(Q);
    bus_start;
    send_byte(8'h98, 0, a); chk("R1 new pin codes acked", a, 1);
    send_byte(8'h7F, 0, a);
    bus_start;
    send_byte(8'h99, 0, a);
    recv_byte(0, d); chk("R5 read at 0x7F", d, 8'h33);
    recv_byte(1, d); chk("R4 read repeats at 0x7F", d, 8'h33);
    bus_stop;
    chk("R4 pointer stays 0x7F on read", reg_addr, 8'h7F);
  endtask

  task automatic t_glitch;
    bit a; int w0 = wr_cnt;
    bus_start;
    send_byte(8'h98, 0, a);
    send_byte(8'h40, 0, a);
    send_byte(8'hFF, 1, a); chk("R8 ack despite spikes", a, 1);
    bus_stop;
    chk("R8 data intact despite spikes", mem[8'h40], 8'hFF);
    chk("R8 one strobe", wr_cnt - w0, 1);
    chk("R8 pointer advanced once", reg_addr, 8'h41);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    w(5);
    t_reset;
    rst_n = 1'b1;
    w(20);
    t_reset;
    t_write_burst;
    t_cmd_only;
    t_saturate_write;
    t_read_rstart;
    t_mismatch;
    t_read_saturate;
    t_glitch;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule